// File: doc/BRIEF.md
# Weighted Round Scheduler with Strict-Priority Head

This block picks which of the queues feeding one egress port is allowed to send next. Each queue holds a 4-bit priority code, written through a simple configuration port. Codes 0 to 8 are weights. Each weight is turned into a fixed 8-bit round-enable mask whose set bits are spread evenly over the eight rounds. Code 9 marks a strict-priority queue. Strict-priority queues are always served before any weighted queue, provided they form one unbroken run that starts at queue 0.

The grant is combinational from the registered scheduler state and the per-queue ready inputs. The consumer pulses `adv_i` while a grant is shown to accept it, and that moves the weighted round-robin pointer. A cycle in which nothing can be granted closes the current round and moves to the next one, modulo 8. Configuration writes land on the clock edge, so weights can be changed while traffic flows. The two error outputs report an order violation and an out-of-range code. Both are live views of the current table.

Top module: `wq_sched`

## Requirements
- R1: After reset every queue holds code 8, the round is 0, no weighted pointer is held, both error outputs are low, and with no queue ready `gnt_valid_o` is low.
- R2: Weight codes map to round masks as 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7F, 8→0xFF. Bit r of the mask enables round r (bit 0 is round 0). A weighted queue can be granted only in rounds whose bit is set.
- R3: A queue with code 0 is never granted.
- R4: Code 9 makes a queue strict-priority when the order rule holds. The lowest-numbered ready strict queue is granted ahead of all weighted queues, and a strict grant leaves the round and the weighted pointer unchanged.
- R5: The order rule holds only when the code-9 queues form a contiguous run starting at queue 0. Otherwise `err_order_o` is high, `port_static_o` is low, and each code-9 queue is scheduled as a weighted queue with mask 0xFF.
- R6: Codes 10 to 15 drive `err_code_o` high, and such a queue is scheduled as weighted with mask 0xFF.
- R7: With no strict queue ready, the grant goes to the lowest-numbered ready weighted queue that is enabled in the current round and lies above the pointer (any queue qualifies when no pointer is held). The pointer takes the granted index only on a cycle where `adv_i` is high.
- R8: A cycle with no ready strict queue and no eligible weighted queue advances the round by one, modulo 8, and clears the pointer.
- R9: `gnt_static_o` marks a strict grant. `gnt_tail_o` marks a grant of queue NUM_Q-1. `gnt_stail_o` marks a strict grant of the last queue in the strict run. `port_static_o` is high when at least one valid strict queue exists.
- R10: A configuration write takes effect on the next cycle, also while grants are flowing.
- R11: `gnt_valid_o` is low when no queue is eligible, and a shown grant always names a queue whose ready bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IW | Queue index to configure |
| cfg_code_i | input | 4 | Priority code: 0-8 weight, 9 strict |
| ready_i | input | NUM_Q | Per-queue has-data indication |
| adv_i | input | 1 | Grant accepted this cycle |
| gnt_valid_o | output | 1 | A grant is shown |
| gnt_idx_o | output | IW | Granted queue index |
| gnt_static_o | output | 1 | Grant is a strict-priority queue |
| gnt_tail_o | output | 1 | Grant is the last queue of the port |
| gnt_stail_o | output | 1 | Grant is the last strict queue |
| port_static_o | output | 1 | Port has a valid strict run |
| round_o | output | 3 | Current round number |
| err_order_o | output | 1 | Strict queues violate the order rule |
| err_code_o | output | 1 | Some queue holds a code above 9 |

## Verification
The bench goes after the round bubble. A design that advanced the round on every grant, or never advanced it, would grant weight-1 and weight-3 queues in the wrong rounds, and the mask checks would catch it at once. It breaks the strict run with a gap to prove that those queues fall back to full-mask weighted service. A design that kept honouring them would show strict grants while the order error is raised. It also holds `adv_i` low over several cycles: a pointer that moved without acceptance would skip queues. A long stretch of pseudo-random ready patterns and live weight rewrites compares every output against an independent model cycle by cycle, and that covers the flags on queue 31 and on the last strict queue.

// File: rtl/wq_sched_pkg.sv
package wq_sched_pkg;
  localparam int ROUNDS = 8;
  localparam int RW     = $clog2(ROUNDS);
  localparam int CW     = 4;
  localparam logic [CW-1:0] CODE_STATIC = 4'd9;

  typedef logic [ROUNDS-1:0] rmask_t;

  // evenly spread round-enable pattern per weight; strict and bad codes get all rounds
  function automatic rmask_t weight_mask(input logic [CW-1:0] code);
    case (code)
      4'd0:    weight_mask = 8'h00;
      4'd1:    weight_mask = 8'h01;
      4'd2:    weight_mask = 8'h11;
      4'd3:    weight_mask = 8'h49;
      4'd4:    weight_mask = 8'h55;
      4'd5:    weight_mask = 8'h57;
      4'd6:    weight_mask = 8'h77;
      4'd7:    weight_mask = 8'h7f;
      default: weight_mask = 8'hff;
    endcase
  endfunction
endpackage

// File: rtl/wq_lowest_pick.sv
module wq_lowest_pick #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign vld_o = |req_i;
endmodule

// File: rtl/wq_cfg_table.sv
module wq_cfg_table
  import wq_sched_pkg::*;
#(
  parameter int NUM_Q = 32,
  parameter int IW    = $clog2(NUM_Q)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [IW-1:0]           idx_i,
  input  logic [CW-1:0]           code_i,
  output logic [NUM_Q-1:0][ROUNDS-1:0] mask_o,
  output logic [NUM_Q-1:0]        static_o,
  output logic                    order_ok_o,
  output logic                    bad_code_o
);
  localparam logic [NUM_Q-1:0] ONE = NUM_Q'(1);

  logic [NUM_Q-1:0][CW-1:0] code_q;
  logic [NUM_Q-1:0]         raw_static, bad;
  logic [NUM_Q-1:0]         st_inc;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) code_q[g] <= 4'd8;
      else if (we_i && idx_i == IW'(g)) code_q[g] <= code_i;
    end
    assign raw_static[g] = code_q[g] == CODE_STATIC;
    assign bad[g]        = code_q[g] > CODE_STATIC;
    assign mask_o[g]     = weight_mask(code_q[g]);
  end

  // strict run valid only as 2^k-1: contiguous from queue 0
  assign st_inc     = raw_static + ONE;
  assign order_ok_o = (raw_static & st_inc) == '0;
  assign static_o   = raw_static & {NUM_Q{order_ok_o}};
  assign bad_code_o = |bad;

  a_r10_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> code_q[$past(idx_i)] == $past(code_i));
endmodule

// File: rtl/wq_sched.sv
module wq_sched
  import wq_sched_pkg::*;
#(
  parameter int NUM_Q = 32,
  parameter int IW    = $clog2(NUM_Q)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IW-1:0]    cfg_idx_i,
  input  logic [CW-1:0]    cfg_code_i,
  input  logic [NUM_Q-1:0] ready_i,
  input  logic             adv_i,
  output logic             gnt_valid_o,
  output logic [IW-1:0]    gnt_idx_o,
  output logic             gnt_static_o,
  output logic             gnt_tail_o,
  output logic             gnt_stail_o,
  output logic             port_static_o,
  output logic [RW-1:0]    round_o,
  output logic             err_order_o,
  output logic             err_code_o
);
  logic [NUM_Q-1:0][ROUNDS-1:0] mask;
  logic [NUM_Q-1:0] is_static, st_req, w_req, above;
  logic             order_ok;
  logic             st_vld, w_vld;
  logic [IW-1:0]    st_idx, w_idx;
  logic [RW-1:0]    round_q;
  logic [IW-1:0]    ptr_q;
  logic             ptr_vld_q;
  logic [NUM_Q:0]   st_ext;
  logic [IW:0]      nxt_idx;

  wq_cfg_table #(.NUM_Q(NUM_Q), .IW(IW)) i_cfg (
    .clk_i, .rst_ni,
    .we_i       (cfg_we_i),
    .idx_i      (cfg_idx_i),
    .code_i     (cfg_code_i),
    .mask_o     (mask),
    .static_o   (is_static),
    .order_ok_o (order_ok),
    .bad_code_o (err_code_o)
  );

  assign st_req = is_static & ready_i;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_elig
    assign above[g] = !ptr_vld_q || (ptr_q < IW'(g));
    assign w_req[g] = ready_i[g] & ~is_static[g] & mask[g][round_q] & above[g];
  end

  wq_lowest_pick #(.N(NUM_Q), .IW(IW)) i_pick_st (.req_i(st_req), .vld_o(st_vld), .idx_o(st_idx));
  wq_lowest_pick #(.N(NUM_Q), .IW(IW)) i_pick_w  (.req_i(w_req),  .vld_o(w_vld),  .idx_o(w_idx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      round_q   <= '0;
      ptr_q     <= '0;
      ptr_vld_q <= 1'b0;
    end else if (!st_vld) begin
      if (w_vld) begin
        if (adv_i) begin
          ptr_q     <= w_idx;
          ptr_vld_q <= 1'b1;
        end
      end else begin
        round_q   <= round_q + 1'b1;
        ptr_vld_q <= 1'b0;
      end
    end
  end

  assign gnt_valid_o   = st_vld | w_vld;
  assign gnt_static_o  = st_vld;
  assign gnt_idx_o     = st_vld ? st_idx : (w_vld ? w_idx : '0);
  assign gnt_tail_o    = gnt_valid_o && (gnt_idx_o == IW'(NUM_Q - 1));
  assign st_ext        = {1'b0, is_static};
  assign nxt_idx       = {1'b0, gnt_idx_o} + 1'b1;
  assign gnt_stail_o   = st_vld && !st_ext[nxt_idx];
  assign port_static_o = |is_static;
  assign err_order_o   = !order_ok;
  assign round_o       = round_q;

  a_r11_grant_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> ready_i[gnt_idx_o]);
  a_r8_idle_steps_round: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_valid_o |=> round_q == $past(round_q) + 3'd1 && !ptr_vld_q);
  a_r4_strict_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_static_o |=> $stable(round_q) && $stable(ptr_q) && $stable(ptr_vld_q));
  a_r7_ptr_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o && !gnt_static_o && ptr_vld_q |-> gnt_idx_o > ptr_q);
  a_r3_round_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o && !gnt_static_o |-> mask[gnt_idx_o][round_q]);
  a_r5_bad_order_no_strict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_order_o |-> !port_static_o && !gnt_static_o);
endmodule

// File: tb/test_wq_sched.sv
module test_wq_sched;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [4:0]  cfg_idx_i = '0;
  logic [3:0]  cfg_code_i = '0;
  logic [31:0] ready_i = '0;
  logic        adv_i = 1'b0;
  logic        gnt_valid_o, gnt_static_o, gnt_tail_o, gnt_stail_o, port_static_o;
  logic        err_order_o, err_code_o;
  logic [4:0]  gnt_idx_o;
  logic [2:0]  round_o;

  always #2 clk_i = ~clk_i;

  wq_sched i_wq_sched (.*);

  typedef struct packed {
    logic v; logic [4:0] idx; logic st; logic tl; logic stl; logic ps;
    logic eo; logic ec; logic [2:0] rnd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0, errors = 0;

  logic [3:0] code_m[32];
  int round_m = 0, ptr_m = 0;
  bit ptr_v = 0;

  function automatic logic [7:0] mask_of(input logic [3:0] c);
    case (c)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h11; 3: return 8'h49;
      4: return 8'h55; 5: return 8'h57; 6: return 8'h77; 7: return 8'h7f;
      default: return 8'hff;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] rdy, input bit adv, input bit we,
                      input int widx, input int wcode, input string tag);
    bit [31:0] st; bit ok, seen_ns, ec; int sidx, gidx; exp_t e; logic [7:0] m;
    @(negedge clk_i);
    ready_i = rdy; adv_i = adv; cfg_we_i = we;
    cfg_idx_i = 5'(widx); cfg_code_i = 4'(wcode);
    ok = 1; seen_ns = 0; ec = 0;
    for (int q = 0; q < 32; q++) begin
      st[q] = code_m[q] == 9;
      if (!st[q]) seen_ns = 1; else if (seen_ns) ok = 0;
      if (code_m[q] > 9) ec = 1;
    end
    if (!ok) st = '0;
    sidx = -1; gidx = -1;
    for (int q = 0; q < 32; q++) if (sidx < 0 && st[q] && rdy[q]) sidx = q;
    for (int q = 0; q < 32; q++) begin
      m = mask_of(code_m[q]);
      if (gidx < 0 && rdy[q] && !st[q] && m[round_m] && (!ptr_v || q > ptr_m)) gidx = q;
    end
    e = '0;
    e.rnd = 3'(round_m); e.eo = !ok; e.ec = ec; e.ps = |st;
    if (sidx >= 0) begin
      e.v = 1; e.idx = 5'(sidx); e.st = 1;
      e.stl = (sidx == 31) || !st[sidx + 1];
    end else if (gidx >= 0) begin
      e.v = 1; e.idx = 5'(gidx);
    end
    e.tl = e.v && e.idx == 5'd31;
    exp_q.push_back(e); tag_q.push_back(tag);
    if (sidx < 0) begin
      if (gidx >= 0) begin
        if (adv) begin ptr_m = gidx; ptr_v = 1; end
      end else begin
        round_m = (round_m + 1) % 8; ptr_v = 0;
      end
    end
    if (we) code_m[widx] = 4'(wcode);
  endtask

  task automatic cfgw(input int idx, input int code, input string tag);
    step('0, 0, 1, idx, code, tag);
  endtask

  // monitor: compares one expected item per cycle
  initial begin
    exp_t e; string t;
    forever begin
      @(negedge clk_i); #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(e.v ? t : "R11", "gnt_valid", gnt_valid_o, e.v);
        if (e.v) chk(t, "gnt_idx", gnt_idx_o, e.idx);
        chk(e.st ? "R4" : t, "gnt_static", gnt_static_o, e.st);
        chk("R9", "gnt_tail", gnt_tail_o, e.tl);
        chk("R9", "gnt_stail", gnt_stail_o, e.stl);
        chk("R9", "port_static", port_static_o, e.ps);
        chk("R5", "err_order", err_order_o, e.eo);
        chk("R6", "err_code", err_code_o, e.ec);
        chk("R8", "round", round_o, e.rnd);
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    for (int q = 0; q < 32; q++) code_m[q] = 4'd8;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1: reset state
    step('0, 0, 0, 0, 0, "R1");
    step('0, 0, 0, 0, 0, "R1");
    // R7: two ready weight-8 queues, with round bubble
    repeat (8) step(32'h5, 1, 0, 0, 0, "R7");
    // R7: no acceptance keeps pointer
    repeat (4) step(32'h5, 0, 0, 0, 0, "R7");
    // R2: weights 0,1,3,8 on q0..q3, others 0
    cfgw(0, 0, "R10"); cfgw(1, 1, "R10"); cfgw(2, 3, "R10");
    for (int q = 4; q < 32; q++) cfgw(q, 0, "R10");
    repeat (60) step(32'hf, 1, 0, 0, 0, "R2");
    // R3: only the weight-0 queue ready
    repeat (10) step(32'h1, 1, 0, 0, 0, "R3");
    // R10: weight change while running
    repeat (3) step(32'h2, 1, 0, 0, 0, "R10");
    step(32'h2, 1, 1, 1, 8, "R10");
    repeat (6) step(32'h2, 1, 0, 0, 0, "R10");
    // R4/R9: strict run q0,q1
    cfgw(0, 9, "R4"); cfgw(1, 9, "R4"); cfgw(2, 5, "R4"); cfgw(31, 8, "R4");
    repeat (4) step(32'h8000_0007, 1, 0, 0, 0, "R4");
    repeat (4) step(32'h0000_0002, 1, 0, 0, 0, "R9");
    repeat (12) step(32'h8000_0004, 1, 0, 0, 0, "R9");
    // R5: gap in strict run
    cfgw(3, 9, "R5");
    repeat (10) step(32'hf, 1, 0, 0, 0, "R5");
    // R6: out-of-range code
    cfgw(3, 13, "R6");
    repeat (10) step(32'h8, 1, 0, 0, 0, "R6");
    cfgw(3, 4, "R6");
    step(32'h8, 1, 0, 0, 0, "R6");
    // R8: pseudo-random traffic with live rewrites
    lf = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      if (lf[31:28] == 4'h0) step(lf, lf[1], 1, int'(lf[12:8]), int'(lf[19:16]) % 10, "R8");
      else step(lf & 32'h8000_00ff, lf[1], 0, 0, 0, "R8");
    end
    repeat (3) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule